// File: doc/BRIEF.md
# Floating-Point Compare and Classify Unit

This block evaluates one relational or classification question about IEEE-754 operands per clock. An operation code chooses between four ordered/unordered compares of operands `a_i` and `b_i`, and a classification test of `a_i` against a five-bit class mask. The answer is a byte-wide predicate, all ones for true and all zeros for false, so it can be written directly into a predicate register file.

The compares are quiet. A NaN operand turns the three ordered tests false without raising a flag, unless that NaN is signalling. The classify operation never raises a flag. A build-time parameter switches the operand format from single to double precision. Results and the invalid flag leave through one register stage.

Top module: `fp_cmp_class`

## Requirements
- R1: `pred_o` is always 8'h00 or 8'hFF and `invalid_o` reflects the same operation. Both are registered and show the result for the inputs sampled at the previous rising clock edge. While `rst_ni` is low both are 0.
- R2: Operation codes are 0 equal, 1 greater-than, 2 greater-or-equal, 3 unordered and 4 classify. Codes 5 to 7 give 8'h00 with `invalid_o` low.
- R3: Equal is true when neither operand is NaN and the operands have the same value. +0 and -0 are equal.
- R4: Greater-than is true when neither operand is NaN and `a_i` is above `b_i`. Values are ordered by sign first, then by magnitude, with the magnitude order reversed for negatives; infinities are the extremes and +0 is not above -0.
- R5: Greater-or-equal is true exactly when greater-than or equal would be true.
- R6: If either operand is a NaN of any kind, equal, greater-than and greater-or-equal are false.
- R7: Unordered is true exactly when at least one operand is a NaN, meaning its exponent is all ones and its fraction is nonzero.
- R8: Classify tests `a_i` using `cls_mask_i`. Bit 0 selects zero of either sign, bit 1 selects normal, bit 2 selects denormal (exponent 0 with a nonzero fraction), bit 3 selects infinity and bit 4 selects NaN. The result is 8'hFF if any selected class matches, including mask 0 giving 8'h00.
- R9: For operation codes 0 to 3, `invalid_o` is high exactly when either operand is a signalling NaN: exponent all ones, fraction nonzero and top fraction bit 0. A quiet NaN does not set it.
- R10: Classify leaves `invalid_o` low for every operand, including a signalling NaN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code |
| a_i | input | W (32 or 64) | First operand, also the classified operand |
| b_i | input | W (32 or 64) | Second operand |
| cls_mask_i | input | 5 | Class select mask for classify |
| pred_o | output | 8 | Predicate result, 8'hFF or 8'h00 |
| invalid_o | output | 1 | Invalid-operation flag |

## Verification
Every result is due exactly one rising edge after its inputs are applied, because the output register is the only sequential stage. The bench drives a new operation on a falling edge and lets one rising edge capture it. It reads `pred_o` and `invalid_o` on the next falling edge, before the following operation is driven. The checker properties use the same one-cycle relation with `|=>`: each ties inputs sampled at one edge to the outputs seen at the next.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;
  typedef enum logic [2:0] {
    OP_EQ    = 3'd0,
    OP_GT    = 3'd1,
    OP_GE    = 3'd2,
    OP_UO    = 3'd3,
    OP_CLASS = 3'd4
  } fpcc_op_e;

  typedef struct packed {
    logic zero;
    logic norm;
    logic denorm;
    logic inf;
    logic qnan;
    logic snan;
  } fpcc_cls_t;

  localparam int unsigned PRED_W = 8;
  localparam int unsigned MASK_W = 5;
endpackage

// File: rtl/fpcc_decode.sv
module fpcc_decode
  import fpcc_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned MAG_W = EXP_W + FRAC_W
) (
  input  logic [MAG_W:0]   val_i,
  output fpcc_cls_t        cls_o,
  output logic             sign_o,
  output logic [MAG_W-1:0] mag_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic exp_max, exp_zero, frac_nz;

  assign exp_f    = val_i[MAG_W-1:FRAC_W];
  assign frac_f   = val_i[FRAC_W-1:0];
  assign exp_max  = &exp_f;
  assign exp_zero = ~|exp_f;
  assign frac_nz  = |frac_f;

  always_comb begin
    cls_o.zero   = exp_zero & ~frac_nz;
    cls_o.denorm = exp_zero &  frac_nz;
    cls_o.norm   = ~exp_zero & ~exp_max;
    cls_o.inf    = exp_max & ~frac_nz;
    cls_o.qnan   = exp_max &  frac_f[FRAC_W-1];
    cls_o.snan   = exp_max &  frac_nz & ~frac_f[FRAC_W-1];
  end

  assign sign_o = val_i[MAG_W];
  assign mag_o  = val_i[MAG_W-1:0];
endmodule

// File: rtl/fpcc_order.sv
module fpcc_order
  import fpcc_pkg::*;
#(
  parameter int unsigned MAG_W = 31
) (
  input  fpcc_cls_t        cls_a_i,
  input  fpcc_cls_t        cls_b_i,
  input  logic             sign_a_i,
  input  logic             sign_b_i,
  input  logic [MAG_W-1:0] mag_a_i,
  input  logic [MAG_W-1:0] mag_b_i,
  output logic             eq_o,
  output logic             gt_o,
  output logic             unord_o
);
  logic both_zero, raw_gt;

  assign unord_o   = cls_a_i.qnan | cls_a_i.snan | cls_b_i.qnan | cls_b_i.snan;
  assign both_zero = cls_a_i.zero & cls_b_i.zero;

  always_comb begin
    unique case ({sign_a_i, sign_b_i})
      2'b00:   raw_gt = mag_a_i > mag_b_i;
      2'b11:   raw_gt = mag_a_i < mag_b_i;
      2'b01:   raw_gt = ~both_zero;
      default: raw_gt = 1'b0;
    endcase
  end

  assign eq_o = ~unord_o & (both_zero | ((sign_a_i == sign_b_i) && (mag_a_i == mag_b_i)));
  assign gt_o = ~unord_o & raw_gt;
endmodule

// File: rtl/fp_cmp_class.sv
module fp_cmp_class
  import fpcc_pkg::*;
#(
  parameter bit DOUBLE = 1'b0,
  localparam int unsigned EXP_W  = DOUBLE ? 11 : 8,
  localparam int unsigned FRAC_W = DOUBLE ? 52 : 23,
  localparam int unsigned MAG_W  = EXP_W + FRAC_W,
  localparam int unsigned W      = MAG_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        op_i,
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  input  logic [MASK_W-1:0] cls_mask_i,
  output logic [PRED_W-1:0] pred_o,
  output logic              invalid_o
);
  fpcc_cls_t        cls   [2];
  logic             sign  [2];
  logic [MAG_W-1:0] mag   [2];
  logic [W-1:0]     opnd  [2];

  assign opnd[0] = a_i;
  assign opnd[1] = b_i;

  for (genvar g = 0; g < 2; g++) begin : g_dec
    fpcc_decode #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dec (
      .val_i (opnd[g]),
      .cls_o (cls[g]),
      .sign_o(sign[g]),
      .mag_o (mag[g])
    );
  end

  logic is_eq, is_gt, is_uo;

  fpcc_order #(.MAG_W(MAG_W)) u_ord (
    .cls_a_i (cls[0]),
    .cls_b_i (cls[1]),
    .sign_a_i(sign[0]),
    .sign_b_i(sign[1]),
    .mag_a_i (mag[0]),
    .mag_b_i (mag[1]),
    .eq_o    (is_eq),
    .gt_o    (is_gt),
    .unord_o (is_uo)
  );

  logic [MASK_W-1:0] cls_vec;
  logic hit, any_snan, truth_d, inv_d;

  // mask bit order: nan, inf, denorm, norm, zero (msb..lsb)
  assign cls_vec  = {cls[0].qnan | cls[0].snan, cls[0].inf, cls[0].denorm,
                     cls[0].norm, cls[0].zero};
  assign any_snan = cls[0].snan | cls[1].snan;

  always_comb begin
    truth_d = 1'b0;
    inv_d   = 1'b0;
    unique case (op_i)
      OP_EQ:    begin truth_d = is_eq;         inv_d = any_snan; end
      OP_GT:    begin truth_d = is_gt;         inv_d = any_snan; end
      OP_GE:    begin truth_d = is_gt | is_eq; inv_d = any_snan; end
      OP_UO:    begin truth_d = is_uo;         inv_d = any_snan; end
      OP_CLASS: truth_d = hit;
      default:  ;
    endcase
  end

  assign hit = |(cls_mask_i & cls_vec);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_o    <= '0;
      invalid_o <= 1'b0;
    end else begin
      pred_o    <= {PRED_W{truth_d}};
      invalid_o <= inv_d;
    end
  end
endmodule

// File: rtl/fpcc_chk.sv
module fpcc_chk #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned W     = EXP_W + FRAC_W + 1
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [2:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [7:0]   pred_o,
  input logic         invalid_o
);
  logic a_nan, b_nan, a_sig, b_sig;
  assign a_nan = (&a_i[W-2:FRAC_W]) && (|a_i[FRAC_W-1:0]);
  assign b_nan = (&b_i[W-2:FRAC_W]) && (|b_i[FRAC_W-1:0]);
  assign a_sig = a_nan && !a_i[FRAC_W-1];
  assign b_sig = b_nan && !b_i[FRAC_W-1];

  // R1
  pred_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_o == 8'h00) || (pred_o == 8'hFF));
  // R6
  quiet_nan_false_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op_i <= 3'd2) && (a_nan || b_nan)) |=> (pred_o == 8'h00));
  // R7
  unord_nan_true_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op_i == 3'd3) && (a_nan || b_nan)) |=> (pred_o == 8'hFF));
  // R9
  invalid_needs_snan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(a_sig || b_sig) |=> !invalid_o);
  // R10
  classify_no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd4) |=> !invalid_o);
  // R2
  unused_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i > 3'd4) |=> (pred_o == 8'h00 && !invalid_o));
endmodule

bind fp_cmp_class fpcc_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .op_i     (op_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .pred_o   (pred_o),
  .invalid_o(invalid_o)
);

// File: tb/fp_cmp_class_test.sv
module fp_cmp_class_test;
  localparam logic [31:0] P0 = 32'h0000_0000, N0 = 32'h8000_0000;
  localparam logic [31:0] P1 = 32'h3F80_0000, N1 = 32'hBF80_0000;
  localparam logic [31:0] P2 = 32'h4000_0000, N2 = 32'hC000_0000;
  localparam logic [31:0] PINF = 32'h7F80_0000, NINF = 32'hFF80_0000;
  localparam logic [31:0] QNAN = 32'h7FC0_0000, SNAN = 32'h7F80_0001;
  localparam logic [31:0] DEN = 32'h0000_0001, MAXF = 32'h7F7F_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] a = '0, b = '0;
  logic [4:0]  mask = '0;
  logic [7:0]  pred;
  logic        inv;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fp_cmp_class uut (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .a_i(a), .b_i(b),
    .cls_mask_i(mask), .pred_o(pred), .invalid_o(inv)
  );

  task automatic run(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y,
                     input logic [4:0] m, input logic [7:0] ep, input logic ei,
                     input string req);
    @(negedge clk);
    op = o; a = x; b = y; mask = m;
    @(negedge clk);
    checks++;
    if (pred !== ep || inv !== ei) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h: pred=%h inv=%b expected pred=%h inv=%b",
               req, o, x, y, pred, inv, ep, ei);
    end
  endtask

  task automatic t_reset;
    checks++;
    if (pred !== 8'h00 || inv !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: pred=%h inv=%b expected pred=00 inv=0", pred, inv);
    end
  endtask

  task automatic t_equal;
    run(3'd0, P1, P1, 5'd0, 8'hFF, 1'b0, "R3");
    run(3'd0, P0, N0, 5'd0, 8'hFF, 1'b0, "R3");
    run(3'd0, P1, N1, 5'd0, 8'h00, 1'b0, "R3");
    run(3'd0, PINF, PINF, 5'd0, 8'hFF, 1'b0, "R3");
  endtask

  task automatic t_greater;
    run(3'd1, P2, P1, 5'd0, 8'hFF, 1'b0, "R4");
    run(3'd1, P1, P2, 5'd0, 8'h00, 1'b0, "R4");
    run(3'd1, N1, N2, 5'd0, 8'hFF, 1'b0, "R4");
    run(3'd1, N2, N1, 5'd0, 8'h00, 1'b0, "R4");
    run(3'd1, P0, N0, 5'd0, 8'h00, 1'b0, "R4");
    run(3'd1, DEN, N0, 5'd0, 8'hFF, 1'b0, "R4");
    run(3'd1, PINF, MAXF, 5'd0, 8'hFF, 1'b0, "R4");
    run(3'd1, NINF, N2, 5'd0, 8'h00, 1'b0, "R4");
    run(3'd1, N1, P0, 5'd0, 8'h00, 1'b0, "R4");
  endtask

  task automatic t_ge;
    run(3'd2, P1, P1, 5'd0, 8'hFF, 1'b0, "R5");
    run(3'd2, N0, P0, 5'd0, 8'hFF, 1'b0, "R5");
    run(3'd2, P2, N2, 5'd0, 8'hFF, 1'b0, "R5");
    run(3'd2, N2, P2, 5'd0, 8'h00, 1'b0, "R5");
  endtask

  task automatic t_nan;
    run(3'd0, QNAN, QNAN, 5'd0, 8'h00, 1'b0, "R6");
    run(3'd1, QNAN, P1, 5'd0, 8'h00, 1'b0, "R6");
    run(3'd2, P1, QNAN, 5'd0, 8'h00, 1'b0, "R6");
    run(3'd3, P1, QNAN, 5'd0, 8'hFF, 1'b0, "R7");
    run(3'd3, SNAN, P1, 5'd0, 8'hFF, 1'b1, "R7");
    run(3'd3, PINF, NINF, 5'd0, 8'h00, 1'b0, "R7");
  endtask

  task automatic t_invalid;
    run(3'd0, SNAN, P1, 5'd0, 8'h00, 1'b1, "R9");
    run(3'd1, P1, SNAN, 5'd0, 8'h00, 1'b1, "R9");
    run(3'd2, QNAN, QNAN, 5'd0, 8'h00, 1'b0, "R9");
  endtask

  task automatic t_classify;
    run(3'd4, N0, P0, 5'b00001, 8'hFF, 1'b0, "R8");
    run(3'd4, P1, P0, 5'b00010, 8'hFF, 1'b0, "R8");
    run(3'd4, DEN, P0, 5'b00100, 8'hFF, 1'b0, "R8");
    run(3'd4, DEN, P0, 5'b11011, 8'h00, 1'b0, "R8");
    run(3'd4, NINF, P0, 5'b01000, 8'hFF, 1'b0, "R8");
    run(3'd4, P1, P0, 5'b00000, 8'h00, 1'b0, "R8");
    run(3'd4, QNAN, P0, 5'b10000, 8'hFF, 1'b0, "R8");
    run(3'd4, P1, DEN, 5'b00100, 8'h00, 1'b0, "R8");
    run(3'd4, SNAN, SNAN, 5'b10000, 8'hFF, 1'b0, "R10");
  endtask

  task automatic t_unused_op;
    run(3'd5, P1, P1, 5'b11111, 8'h00, 1'b0, "R2");
    run(3'd7, SNAN, SNAN, 5'b11111, 8'h00, 1'b0, "R2");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_equal();
    t_greater();
    t_ge();
    t_nan();
    t_invalid();
    t_classify();
    t_unused_op();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule